// File: doc/BRIEF.md
# Latency-Scheduled Writeback Ring

This block holds the results of operations that are still in flight and hands each one back on exactly the issue step at which its latency runs out. It is a circular store of `MAX_LAT` data slots with a single head pointer. Every accepted issue step does three things in a fixed order. It reads the slot under the head as the value to write back. It zeroes that slot and moves the head forward by one, wrapping at `MAX_LAT`. If the issued operation yields a result, it then files that result `latency - 1` slots past the advanced head.

A sequencer pulses `issue` once per issued instruction. It drives `halt` together with `issue` for a terminating instruction, which makes the step do nothing. It also presents the operation's result and latency. The register file consumes `wb_data` when `wb_en` is high, one clock after the strobe. The ring is not a FIFO. Results are written ahead into positions derived from their latency, so a later short-latency result can come out before an earlier long one, or overwrite it.

Top module: `lat_ring`

## Requirements
- R1: While `rst_n` is low and after its release, `wb_en` and `lat_err` are 0, the head is at slot 0 and every slot holds zero, so the first writebacks after reset carry 0.
- R2: A clock edge with `issue`=1 and `halt`=0 is an accepted step. On the next clock `wb_en` is 1 and `wb_data` is the value the slot under the head held before that step.
- R3: A result accepted with latency L (1 ≤ L ≤ `MAX_LAT`) appears on `wb_data` for the L-th accepted step after the step that delivered it, and a step with L=1 returns it on the very next accepted step.
- R4: Reading a slot clears it, so a delivered value is returned only once, and the same slot reads 0 one full turn later unless something new was filed there.
- R5: The head wraps modulo `MAX_LAT`. A latency of exactly `MAX_LAT` files the result in the slot that the same step has just cleared, and the insert wins over the clear.
- R6: A step with `issue`=1 and `halt`=1 gives `wb_en`=0 on the next clock, leaves the head where it was and files nothing.
- R7: On cycles with `issue`=0, `wb_en` is 0 on the next clock, the head holds and the result inputs are ignored.
- R8: An accepted step with `res_valid`=0 files nothing, and every slot other than the one being read keeps its contents.
- R9: An accepted step with `res_valid`=1 and a latency of 0 or above `MAX_LAT` sets `lat_err` for one clock on the next edge and files nothing. Its writeback still takes place. `lat_err` is 0 after every other cycle.
- R10: When two accepted results are aimed at the same slot, the one filed later replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Issue strobe, one per instruction step |
| halt | input | 1 | Marks the issued instruction as terminating; cancels the step |
| res_valid | input | 1 | The issued operation produces a result |
| res_lat | input | LAT_W (5) | Latency of the result in issue steps |
| res_data | input | DATA_W (32) | Result value |
| wb_en | output | 1 | Registered writeback strobe |
| wb_data | output | DATA_W (32) | Registered writeback value |
| lat_err | output | 1 | Registered pulse flagging a rejected latency |

## Verification
Within a single step, the clear of the slot under the head and the insert of a new result can both target the same slot. This happens when the latency equals `MAX_LAT` and the insert index wraps back onto the old head. The bench files a marked value with that latency and then issues `MAX_LAT` steps. It expects zeros on all steps except the last, which must return the marked value. A wrong clear/insert priority returns zero there instead. It also aims two results at one slot from successive steps and expects only the second one back.

// File: rtl/lat_ring_pkg.sv
package lat_ring_pkg;
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_HALT = 2'd1,
      STEP_RUN  = 2'd2
   } step_e;

   function automatic step_e decode_step(input logic iss, input logic hlt);
      if (!iss)     return STEP_IDLE;
      else if (hlt) return STEP_HALT;
      else          return STEP_RUN;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/lat_ring_head.sv
module lat_ring_head #(
   parameter int MAX_LAT = 16,
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] head
);
   import lat_ring_pkg::*;

   logic [IDX_W-1:0] head_nxt;

   generate
      if (is_pow2(MAX_LAT)) begin : g_pow2
         assign head_nxt = head + IDX_W'(1);
      end else begin : g_wrap
         assign head_nxt = (head == IDX_W'(MAX_LAT - 1)) ? '0 : head + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    head <= '0;
      else if (step) head <= head_nxt;
   end
endmodule

// File: rtl/lat_ring_place.sv
module lat_ring_place #(
   parameter int MAX_LAT = 16,
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1,
   localparam int LAT_W  = $clog2(MAX_LAT + 1),
   localparam int SUM_W  = LAT_W + 1
) (
   input  logic [IDX_W-1:0] head,
   input  logic [LAT_W-1:0] lat,
   output logic             lat_ok,
   output logic [IDX_W-1:0] idx
);
   import lat_ring_pkg::*;

   logic [SUM_W-1:0] sum;

   // Position relative to the pre-step head: (head + 1) + (lat - 1).
   assign sum    = SUM_W'(head) + SUM_W'(lat);
   assign lat_ok = (lat != '0) && (SUM_W'(lat) <= SUM_W'(MAX_LAT));

   generate
      if (is_pow2(MAX_LAT)) begin : g_pow2
         assign idx = sum[IDX_W-1:0];
      end else begin : g_fold
         logic [SUM_W-1:0] folded;
         assign folded = (sum >= SUM_W'(MAX_LAT)) ? sum - SUM_W'(MAX_LAT) : sum;
         assign idx    = folded[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/lat_ring_slots.sv
module lat_ring_slots #(
   parameter int MAX_LAT = 16,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              ins_en,
   input  logic [IDX_W-1:0]  ins_idx,
   input  logic [DATA_W-1:0] ins_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [MAX_LAT];

   assign rd_data = mem[clr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_LAT; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < MAX_LAT; i++) begin
            if (clr_en && (clr_idx == IDX_W'(i))) mem[i] <= '0;
            // insert comes after the clear in the step, so it takes priority
            if (ins_en && (ins_idx == IDX_W'(i))) mem[i] <= ins_data;
         end
      end
   end
endmodule

// File: rtl/lat_ring.sv
module lat_ring #(
   parameter int MAX_LAT = 16,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1,
   localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              halt,
   input  logic              res_valid,
   input  logic [LAT_W-1:0]  res_lat,
   input  logic [DATA_W-1:0] res_data,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data,
   output logic              lat_err
);
   import lat_ring_pkg::*;

   generate
      if (MAX_LAT < 2)  begin : g_bad_depth $error("lat_ring: MAX_LAT must be at least 2"); end
      if (DATA_W < 1)   begin : g_bad_width $error("lat_ring: DATA_W must be positive"); end
   endgenerate

   step_e            step_kind;
   logic             run;
   logic [IDX_W-1:0] head;
   logic [IDX_W-1:0] ins_idx;
   logic             lat_ok;
   logic             ins_en;
   logic [DATA_W-1:0] head_val;

   assign step_kind = decode_step(issue, halt);
   assign run       = (step_kind == STEP_RUN);
   assign ins_en    = run && res_valid && lat_ok;

   lat_ring_head #(.MAX_LAT(MAX_LAT)) u_head (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (run),
      .head  (head)
   );

   lat_ring_place #(.MAX_LAT(MAX_LAT)) u_place (
      .head   (head),
      .lat    (res_lat),
      .lat_ok (lat_ok),
      .idx    (ins_idx)
   );

   lat_ring_slots #(.MAX_LAT(MAX_LAT), .DATA_W(DATA_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (run),
      .clr_idx  (head),
      .ins_en   (ins_en),
      .ins_idx  (ins_idx),
      .ins_data (res_data),
      .rd_data  (head_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en   <= 1'b0;
         wb_data <= '0;
         lat_err <= 1'b0;
      end else begin
         wb_en   <= run;
         lat_err <= run && res_valid && !lat_ok;
         if (run) wb_data <= head_val;
      end
   end
endmodule

// File: rtl/lat_ring_sva.sv
module lat_ring_sva #(
   parameter int MAX_LAT = 16,
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1,
   localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue,
   input logic             halt,
   input logic             res_valid,
   input logic [LAT_W-1:0] res_lat,
   input logic [IDX_W-1:0] head,
   input logic             wb_en,
   input logic             lat_err
);
   logic run;
   logic bad_lat;
   assign run     = issue && !halt;
   assign bad_lat = (res_lat == '0) || (int'(res_lat) > MAX_LAT);

   AST_RUN_GIVES_WB: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> wb_en); // R2
   AST_HALT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && halt) |=> (!wb_en && $stable(head))); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (!wb_en && $stable(head))); // R7
   AST_HEAD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (int'(head) == ((int'($past(head)) + 1) % MAX_LAT))); // R5
   AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(head) < MAX_LAT); // R5
   AST_BAD_LAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (run && res_valid && bad_lat) |=> lat_err); // R9
   AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && res_valid && bad_lat) |=> !lat_err); // R9
endmodule

bind lat_ring lat_ring_sva #(.MAX_LAT(MAX_LAT)) u_lat_ring_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue     (issue),
   .halt      (halt),
   .res_valid (res_valid),
   .res_lat   (res_lat),
   .head      (head),
   .wb_en     (wb_en),
   .lat_err   (lat_err)
);

// File: tb/lat_ring_bench.sv
`timescale 1ns/1ps
module lat_ring_bench;
   localparam int M  = 16;
   localparam int DW = 32;
   localparam int LW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue = 1'b0, halt = 1'b0, res_valid = 1'b0;
   logic [LW-1:0] res_lat = '0;
   logic [DW-1:0] res_data = '0;
   logic          wb_en, lat_err;
   logic [DW-1:0] wb_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   lat_ring #(.MAX_LAT(M), .DATA_W(DW)) u_lat_ring (
      .clk(clk), .rst_n(rst_n), .issue(issue), .halt(halt),
      .res_valid(res_valid), .res_lat(res_lat), .res_data(res_data),
      .wb_en(wb_en), .wb_data(wb_data), .lat_err(lat_err)
   );

   typedef struct packed {
      logic          iss;
      logic          hlt;
      logic          vld;
      logic [LW-1:0] lat;
      logic [DW-1:0] dat;
      logic          e_en;
      logic [DW-1:0] e_wb;
      logic          e_err;
      logic [3:0]    req;
   } row_t;

   localparam int NROW = 16;
   localparam row_t TBL [NROW] = '{
      '{1'b1,1'b0,1'b1,5'd1, 32'hA1A1_0001, 1'b1,32'h0,           1'b0,4'd1},  // R1 first read is 0
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'hA1A1_0001,  1'b0,4'd3},  // R3 latency 1
      '{1'b1,1'b0,1'b1,5'd3, 32'hB3B3_0003, 1'b1,32'h0,           1'b0,4'd2},  // R2
      '{1'b1,1'b0,1'b1,5'd1, 32'hC1C1_0001, 1'b1,32'h0,           1'b0,4'd8},  // R8
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'hC1C1_0001,  1'b0,4'd3},  // R3 short overtakes long
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'hB3B3_0003,  1'b0,4'd3},  // R3 latency 3
      '{1'b0,1'b0,1'b1,5'd1, 32'hDDDD_DDDD, 1'b0,32'hB3B3_0003,  1'b0,4'd7},  // R7 idle
      '{1'b1,1'b1,1'b1,5'd1, 32'hEEEE_EEEE, 1'b0,32'hB3B3_0003,  1'b0,4'd6},  // R6 halt
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'h0,           1'b0,4'd7},  // R7 nothing filed
      '{1'b1,1'b0,1'b1,5'd0, 32'h7777_7777, 1'b1,32'h0,           1'b1,4'd9},  // R9 latency 0
      '{1'b1,1'b0,1'b1,5'd17,32'h8888_8888, 1'b1,32'h0,           1'b1,4'd9},  // R9 latency too big
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'h0,           1'b0,4'd9},  // R9 nothing filed
      '{1'b1,1'b0,1'b1,5'd3, 32'hF3F3_0003, 1'b1,32'h0,           1'b0,4'd10}, // R10
      '{1'b1,1'b0,1'b1,5'd2, 32'hF2F2_0002, 1'b1,32'h0,           1'b0,4'd10}, // R10 same slot
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'h0,           1'b0,4'd10}, // R10
      '{1'b1,1'b0,1'b0,5'd0, 32'h0,         1'b1,32'hF2F2_0002,  1'b0,4'd10}  // R10 later one wins
   };

   task automatic step(input logic i, input logic h, input logic v,
                       input logic [LW-1:0] l, input logic [DW-1:0] d);
      @(negedge clk);
      issue = i; halt = h; res_valid = v; res_lat = l; res_data = d;
      @(posedge clk);
      #1;
      issue = 1'b0; halt = 1'b0; res_valid = 1'b0;
   endtask

   task automatic check(input int req, input logic e_en, input logic [DW-1:0] e_wb,
                        input logic e_err);
      checks++;
      if (wb_en !== e_en || lat_err !== e_err || (e_en && wb_data !== e_wb)) begin
         fails++;
         $display("FAIL R%0d: en=%0b wb=%h err=%0b expected en=%0b wb=%h err=%0b",
                  req, wb_en, wb_data, lat_err, e_en, e_wb, e_err);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(1, 1'b0, '0, 1'b0); // R1 during reset
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check(1, 1'b0, '0, 1'b0); // R1 after release

      for (int r = 0; r < NROW; r++) begin
         step(TBL[r].iss, TBL[r].hlt, TBL[r].vld, TBL[r].lat, TBL[r].dat);
         check(int'(TBL[r].req), TBL[r].e_en, TBL[r].e_wb, TBL[r].e_err);
      end

      // R5: latency MAX_LAT lands on the slot cleared in the same step
      step(1'b1, 1'b0, 1'b1, 5'(M), 32'h6161_0010);
      check(5, 1'b1, '0, 1'b0);
      for (int k = 1; k < M; k++) begin
         step(1'b1, 1'b0, 1'b0, '0, '0);
         check(4, 1'b1, '0, 1'b0); // R4 earlier values were returned once only
      end
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(5, 1'b1, 32'h6161_0010, 1'b0); // R5 insert beat the clear
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(2, 1'b1, '0, 1'b0);
      for (int k = 1; k < M; k++) step(1'b1, 1'b0, 1'b0, '0, '0);
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(4, 1'b1, '0, 1'b0); // R4 slot is empty one turn later

      // R1: reset discards filed results
      step(1'b1, 1'b0, 1'b1, 5'd2, 32'h5A5A_5A5A);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      check(1, 1'b0, '0, 1'b0);
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(1, 1'b1, '0, 1'b0);
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(1, 1'b1, '0, 1'b0);
      step(1'b1, 1'b0, 1'b0, '0, '0);
      check(1, 1'b1, '0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule